// File: doc/BRIEF.md
# DRAM Initialization Command Sequencer

This block places single DRAM commands onto a narrow command interface, either on behalf of software through a 32-bit command register, or from a built-in power-up sequencer. A command word carries a start flag, a rank mask, a bank, a row/mode address and a command code. The start flag reads back as 1 while the command is still waiting to go out, and it clears once the command has been issued. Only one command can be pending at a time.

The built-in sequencer runs the DDR3 bring-up order. It sends a deselect and a precharge-all, then loads the mode registers in the order 2, 3, 1, 0, with the DLL-reset bit forced in mode register 0. It then issues a long ZQ calibration. After that it asks the PHY to calibrate its read gate and waits for every byte lane to report done. While it waits, the effective refresh interval handed to the refresh engine is forced to zero, which stops auto-refresh. Once calibration ends, three refreshes make up for the lost time, and then the configured interval comes back.

Issue is paced by `phy_rdy`. A pending command goes out on the first clock edge at which `phy_rdy` is sampled high. It then appears on the command pins for exactly one cycle, marked by `dram_issue`. In every other cycle the pins carry deselect, which is all zeros. Holding `phy_rdy` low stalls the pending command indefinitely, and nothing is lost.

Top module: `dinit_cmd_seq`

## Requirements
- R1: The command word layout is: start flag at bit 31, rank mask at bits 27:20, bank at bits 19:17, address at bits 16:4 and command code at bits 3:0. Software accepts a word only when bit 31 is 1. After an accepted write, `sw_rdata` returns the written bits 30:0, with bit 31 equal to 1 while the command is pending.
- R2: An issued command drives `dram_cmd` = word[3:0], `dram_rank` = word[20 +: RANKS], `dram_bank` = word[19:17] and `dram_addr` = word[16:4]. The codes are: deselect 0, precharge-all 1, refresh 2, mode-register set 3, short ZQ 4, long ZQ 5, reset-low 6 and mode-register read 8.
- R3: A pending command is issued at the first rising edge at which `phy_rdy` is high. At that same edge `sw_rdata[31]` clears. No command is issued after an edge at which `phy_rdy` was low.
- R4: `dram_issue` is high for exactly one cycle per command. Whenever it is low, `dram_cmd`, `dram_rank`, `dram_bank` and `dram_addr` are all 0 (deselect).
- R5: A software write while a command is pending or the sequencer is busy is ignored and sets `err_flag`, which stays set until reset. A write with bit 31 = 0 at any other time is ignored and leaves `err_flag` unchanged.
- R6: After an `init_start` pulse, the sequencer issues the following commands, all with rank mask all-ones: deselect; precharge-all; mode-register set to bank 2 with `mr2`; to bank 3 with `mr3`; to bank 1 with `mr1`; to bank 0 with `mr0` and bit 8 forced to 1; then long ZQ (code 5) with address 0.
- R7: After the long ZQ has been issued, `cal_req` is high and `refi_eff` is 0. Both stay that way until all bits of `cal_done` are high in the same cycle.
- R8: After calibration, exactly three refresh commands (code 2, rank mask all-ones) are issued. `refi_eff` stays 0 until the third refresh has been issued and the sequence ends, and afterwards it equals `refi_cfg`.
- R9: `busy` is high from the cycle after an accepted `init_start` until the sequence ends. `done` is high for one cycle, which is the first cycle with `busy` low. An `init_start` while busy is ignored.
- R10: After reset, `busy`, `done`, `cal_req`, `err_flag`, `dram_issue`, all command pins and `sw_rdata` are 0, and `refi_eff` equals `refi_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software write strobe for the command register |
| sw_wdata | input | 32 | Command word written by software |
| sw_rdata | output | 32 | Command register readback, bit 31 = pending |
| err_flag | output | 1 | Sticky: a write arrived while blocked |
| init_start | input | 1 | Pulse that starts the bring-up sequence |
| mr0 | input | 13 | Mode register 0 value |
| mr1 | input | 13 | Mode register 1 value |
| mr2 | input | 13 | Mode register 2 value |
| mr3 | input | 13 | Mode register 3 value |
| refi_cfg | input | REFI_W | Configured refresh interval |
| refi_eff | output | REFI_W | Interval given to the refresh engine (0 = off) |
| cal_done | input | LANES | Per-byte-lane calibration done |
| cal_req | output | 1 | Read-gate calibration request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| phy_rdy | input | 1 | Command slot available this edge |
| dram_issue | output | 1 | A command is on the pins this cycle |
| dram_cmd | output | 4 | Command code |
| dram_rank | output | RANKS | Rank mask |
| dram_bank | output | 3 | Bank address |
| dram_addr | output | 13 | Row / mode address |

## Verification
Software commands are driven in two ways. In the first, `phy_rdy` is held low and then released, which separates a stalled command from one that is issued early. In the second, random fields and random `phy_rdy` gaps are used, which exposes fields that are crossed or dropped on their way to the pins. Writes are also made while a command is pending and with the start flag clear, which separates the "ignored with error" case from the "ignored silently" case. The bring-up sequence runs under random issue gaps, with only one lane reporting done for a while and a stray `init_start` in the middle. This shows the mode-register order, the forced DLL-reset bit, the all-lanes condition, the refresh suppression window and the refresh count.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
  localparam int WORD_W   = 32;
  localparam int START_B  = 31;
  localparam int RANK_LSB = 20;
  localparam int RANK_FW  = 8;
  localparam int BANK_LSB = 17;
  localparam int BANK_W   = 3;
  localparam int ADDR_LSB = 4;
  localparam int ADDR_W   = 13;
  localparam int CODE_W   = 4;
  localparam int DLL_RST_B = 8;

  typedef enum logic [CODE_W-1:0] {
    CMD_DES  = 4'd0,
    CMD_PREA = 4'd1,
    CMD_REF  = 4'd2,
    CMD_MRS  = 4'd3,
    CMD_ZQS  = 4'd4,
    CMD_ZQL  = 4'd5,
    CMD_RSTL = 4'd6,
    CMD_MRR  = 4'd8
  } cmd_code_e;

  typedef struct packed {
    logic [RANK_FW-1:0] rank;
    logic [BANK_W-1:0]  bank;
    logic [ADDR_W-1:0]  addr;
    logic [CODE_W-1:0]  code;
  } dram_cmd_t;

  // Lower 31 bits of a command word built from its fields.
  function automatic logic [WORD_W-2:0] pack_word(dram_cmd_t c);
    return {3'b000, c.rank, c.bank, c.addr, c.code};
  endfunction
endpackage

// File: rtl/dinit_cmd_reg.sv
module dinit_cmd_reg
  import dinit_pkg::*;
#(
  parameter int RANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr,
  input  logic [WORD_W-1:0]    sw_wdata,
  input  logic                 seq_busy,
  input  logic                 seq_ld,
  input  dram_cmd_t            seq_cmd,
  input  logic                 phy_rdy,
  output logic                 pending,
  output logic [WORD_W-1:0]    rdata,
  output logic                 err,
  output logic                 issue,
  output logic [CODE_W-1:0]    out_code,
  output logic [RANKS-1:0]     out_rank,
  output logic [BANK_W-1:0]    out_bank,
  output logic [ADDR_W-1:0]    out_addr
);
  logic [WORD_W-2:0] word_q;
  logic              pend_q;
  logic              sw_take, sw_bad, load, fire;
  logic [WORD_W-2:0] word_d;

  assign sw_take = sw_wr && sw_wdata[START_B] && !pend_q && !seq_busy;
  assign sw_bad  = sw_wr && (pend_q || seq_busy);
  assign load    = sw_take || (seq_ld && !pend_q);
  assign fire    = pend_q && phy_rdy;
  assign word_d  = sw_take ? sw_wdata[WORD_W-2:0] : pack_word(seq_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pend_q <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (load) begin
        word_q <= word_d;
        pend_q <= 1'b1;
      end else if (fire) begin
        pend_q <= 1'b0;
      end
      if (sw_bad) err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue    <= 1'b0;
      out_code <= '0;
      out_rank <= '0;
      out_bank <= '0;
      out_addr <= '0;
    end else begin
      issue    <= fire;
      out_code <= fire ? word_q[CODE_W-1:0]            : '0;
      out_rank <= fire ? word_q[RANK_LSB +: RANKS]     : '0;
      out_bank <= fire ? word_q[BANK_LSB +: BANK_W]    : '0;
      out_addr <= fire ? word_q[ADDR_LSB +: ADDR_W]    : '0;
    end
  end

  assign pending = pend_q;
  assign rdata   = {pend_q, word_q};
endmodule

// File: rtl/dinit_seq.sv
module dinit_seq
  import dinit_pkg::*;
#(
  parameter int RANKS = 2,
  parameter int LANES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_start,
  input  logic              pending,
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  input  logic [ADDR_W-1:0] mr3,
  input  logic [LANES-1:0]  cal_done,
  output logic              busy,
  output logic              done,
  output logic              seq_ld,
  output dram_cmd_t         seq_cmd,
  output logic              cal_req,
  output logic              refi_mask
);
  localparam int STEP_W    = 4;
  localparam int LAST_INIT = 6;
  localparam int FIRST_REF = 7;
  localparam int LAST_STEP = 9;
  localparam logic [RANK_FW-1:0] ALL_RANKS = RANK_FW'((1 << RANKS) - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_CAL} st_e;

  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic              last_ok;

  always_comb begin
    seq_cmd      = '0;
    seq_cmd.rank = ALL_RANKS;
    unique case (step_q)
      4'd0: seq_cmd.code = CMD_DES;
      4'd1: seq_cmd.code = CMD_PREA;
      4'd2: begin seq_cmd.code = CMD_MRS; seq_cmd.bank = 3'd2; seq_cmd.addr = mr2; end
      4'd3: begin seq_cmd.code = CMD_MRS; seq_cmd.bank = 3'd3; seq_cmd.addr = mr3; end
      4'd4: begin seq_cmd.code = CMD_MRS; seq_cmd.bank = 3'd1; seq_cmd.addr = mr1; end
      4'd5: begin
        seq_cmd.code = CMD_MRS;
        seq_cmd.bank = 3'd0;
        seq_cmd.addr = mr0 | ADDR_W'(1 << DLL_RST_B);
      end
      4'd6: seq_cmd.code = CMD_ZQL;
      default: seq_cmd.code = CMD_REF;
    endcase
  end

  assign last_ok = (st_q == S_WAIT) && !pending && (step_q == STEP_W'(LAST_STEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_ok;
      unique case (st_q)
        S_IDLE: if (init_start && !pending) begin
          st_q   <= S_ISSUE;
          step_q <= '0;
        end
        S_ISSUE: if (!pending) st_q <= S_WAIT;
        S_WAIT: if (!pending) begin
          if (step_q == STEP_W'(LAST_INIT)) st_q <= S_CAL;
          else if (step_q == STEP_W'(LAST_STEP)) st_q <= S_IDLE;
          else begin
            step_q <= step_q + 1'b1;
            st_q   <= S_ISSUE;
          end
        end
        S_CAL: if (&cal_done) begin
          step_q <= STEP_W'(FIRST_REF);
          st_q   <= S_ISSUE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign seq_ld    = (st_q == S_ISSUE) && !pending;
  assign cal_req   = (st_q == S_CAL);
  assign refi_mask = cal_req || (busy && step_q >= STEP_W'(FIRST_REF));
endmodule

// File: rtl/dinit_cmd_seq.sv
module dinit_cmd_seq
  import dinit_pkg::*;
#(
  parameter int RANKS  = 2,
  parameter int LANES  = 2,
  parameter int REFI_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  output logic              err_flag,
  input  logic              init_start,
  input  logic [12:0]       mr0,
  input  logic [12:0]       mr1,
  input  logic [12:0]       mr2,
  input  logic [12:0]       mr3,
  input  logic [REFI_W-1:0] refi_cfg,
  output logic [REFI_W-1:0] refi_eff,
  input  logic [LANES-1:0]  cal_done,
  output logic              cal_req,
  output logic              busy,
  output logic              done,
  input  logic              phy_rdy,
  output logic              dram_issue,
  output logic [3:0]        dram_cmd,
  output logic [RANKS-1:0]  dram_rank,
  output logic [2:0]        dram_bank,
  output logic [12:0]       dram_addr
);
  logic      pending, seq_ld, refi_mask;
  dram_cmd_t seq_cmd;

  dinit_seq #(.RANKS(RANKS), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .pending(pending),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3), .cal_done(cal_done),
    .busy(busy), .done(done), .seq_ld(seq_ld), .seq_cmd(seq_cmd),
    .cal_req(cal_req), .refi_mask(refi_mask)
  );

  dinit_cmd_reg #(.RANKS(RANKS)) u_reg (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .seq_busy(busy), .seq_ld(seq_ld), .seq_cmd(seq_cmd), .phy_rdy(phy_rdy),
    .pending(pending), .rdata(sw_rdata), .err(err_flag), .issue(dram_issue),
    .out_code(dram_cmd), .out_rank(dram_rank), .out_bank(dram_bank),
    .out_addr(dram_addr)
  );

  assign refi_eff = refi_mask ? '0 : refi_cfg;
endmodule

// File: rtl/dinit_cmd_seq_chk.sv
module dinit_cmd_seq_chk #(
  parameter int RANKS  = 2,
  parameter int LANES  = 2,
  parameter int REFI_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       sw_rdata,
  input logic              err_flag,
  input logic [REFI_W-1:0] refi_eff,
  input logic [LANES-1:0]  cal_done,
  input logic              cal_req,
  input logic              busy,
  input logic              done,
  input logic              phy_rdy,
  input logic              dram_issue,
  input logic [3:0]        dram_cmd,
  input logic [RANKS-1:0]  dram_rank,
  input logic [2:0]        dram_bank,
  input logic [12:0]       dram_addr
);
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dram_issue |=> !dram_issue); // R4
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_issue |-> (dram_cmd == 4'd0 && dram_rank == '0 && dram_bank == 3'd0 && dram_addr == 13'd0)); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[31] && phy_rdy) |=> (!sw_rdata[31] && dram_issue)); // R3
  AST_NO_ISSUE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rdy |=> !dram_issue); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R5
  AST_CAL_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> (refi_eff == '0)); // R7
  AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && !(&cal_done)) |=> cal_req); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
endmodule

bind dinit_cmd_seq dinit_cmd_seq_chk #(.RANKS(RANKS), .LANES(LANES), .REFI_W(REFI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rdata(sw_rdata), .err_flag(err_flag),
  .refi_eff(refi_eff), .cal_done(cal_done), .cal_req(cal_req), .busy(busy),
  .done(done), .phy_rdy(phy_rdy), .dram_issue(dram_issue), .dram_cmd(dram_cmd),
  .dram_rank(dram_rank), .dram_bank(dram_bank), .dram_addr(dram_addr)
);

// File: tb/dinit_cmd_seq_tb.sv
module dinit_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RANKS = 2;
  localparam int LANES = 2;
  localparam int REFI_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic err_flag;
  logic init_start = 1'b0;
  logic [12:0] mr0 = 13'h0420, mr1 = 13'h0042, mr2 = 13'h0018, mr3 = 13'h0003;
  logic [REFI_W-1:0] refi_cfg = 16'h0060;
  logic [REFI_W-1:0] refi_eff;
  logic [LANES-1:0] cal_done = '0;
  logic cal_req, busy, done;
  logic phy_rdy = 1'b0;
  logic dram_issue;
  logic [3:0] dram_cmd;
  logic [RANKS-1:0] dram_rank;
  logic [2:0] dram_bank;
  logic [12:0] dram_addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit rdy_rand = 1'b0;
  bit rdy_val = 1'b0;
  logic [21:0] log_q [0:63];
  int log_n = 0;
  int done_n = 0;
  int idle_viol = 0;

  dinit_cmd_seq #(.RANKS(RANKS), .LANES(LANES), .REFI_W(REFI_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) phy_rdy <= rdy_rand ? 1'($urandom % 2) : rdy_val;

  // Monitor: log issued commands, count done pulses, watch idle pins (R4)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (dram_issue) begin
        if (log_n < 64) log_q[log_n] = {dram_cmd, dram_rank, dram_bank, dram_addr};
        log_n++;
      end else if ({dram_cmd, dram_rank, dram_bank, dram_addr} != '0) idle_viol++;
      if (done) done_n++;
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [31:0] w);
    @(negedge clk);
    sw_wr = 1'b1;
    sw_wdata = w;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  function automatic logic [31:0] mk_word(logic [3:0] c, logic [1:0] r, logic [2:0] b, logic [12:0] a);
    return {1'b1, 3'b0, 6'b0, r, b, a, c};
  endfunction

  function automatic logic [21:0] exp_seq(int s);
    logic [12:0] m0f;
    m0f = mr0 | 13'h100;
    case (s)
      0: return {4'd0, 2'b11, 3'd0, 13'd0};
      1: return {4'd1, 2'b11, 3'd0, 13'd0};
      2: return {4'd3, 2'b11, 3'd2, mr2};
      3: return {4'd3, 2'b11, 3'd3, mr3};
      4: return {4'd3, 2'b11, 3'd1, mr1};
      5: return {4'd3, 2'b11, 3'd0, m0f};
      6: return {4'd5, 2'b11, 3'd0, 13'd0};
      default: return {4'd2, 2'b11, 3'd0, 13'd0};
    endcase
  endfunction

  task automatic wait_clear();
    do @(negedge clk); while (sw_rdata[31]);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] w;
    int base;
    int n0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rdata", sw_rdata, 0);
    chk("R10 flags", {busy, done, cal_req, err_flag, dram_issue}, 0);
    chk("R10 refi", refi_eff, refi_cfg);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: write without start flag is ignored silently
    sw_write(32'h0000_1234);
    repeat (3) @(negedge clk);
    chk("R5 no-start rdata", sw_rdata, 0);
    chk("R5 no-start err", err_flag, 0);
    chk("R5 no-start issue", log_n, 0);

    // R1/R3: stalled command
    rdy_val = 1'b0;
    w = mk_word(4'd3, 2'b01, 3'd5, 13'h1abc);
    sw_write(w);
    chk("R1 readback", sw_rdata, w);
    repeat (4) @(negedge clk);
    chk("R3 stalled no issue", log_n, 0);
    chk("R3 still pending", sw_rdata[31], 1);
    // R5: write while pending
    sw_write(mk_word(4'd2, 2'b10, 3'd1, 13'h0001));
    chk("R5 err set", err_flag, 1);
    chk("R5 word unchanged", sw_rdata, w);
    rdy_val = 1'b1;
    n0 = 0;
    while (!dram_issue && n0 < 6) begin @(negedge clk); n0++; end
    chk("R2 fields", {dram_cmd, dram_rank, dram_bank, dram_addr}, {4'd3, 2'b01, 3'd5, 13'h1abc});
    chk("R3 start cleared", sw_rdata[31], 0);
    @(negedge clk);
    chk("R4 one cycle", dram_issue, 0);
    chk("R4 deselect", {dram_cmd, dram_rank, dram_bank, dram_addr}, 0);
    chk("R5 err sticky", err_flag, 1);

    // R2: random commands under random phy_rdy gaps
    rdy_rand = 1'b1;
    base = log_n;
    for (int k = 0; k < 20; k++) begin
      logic [3:0] codes [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8};
      logic [3:0] c;
      logic [1:0] r;
      logic [2:0] b;
      logic [12:0] a;
      c = codes[$urandom % 8];
      r = 2'($urandom);
      b = 3'($urandom);
      a = 13'($urandom);
      sw_write(mk_word(c, r, b, a));
      wait_clear();
      chk("R2 random cmd", log_q[base + k], {c, r, b, a});
    end

    // R6-R9: bring-up sequence
    base = log_n;
    n0 = done_n;
    @(negedge clk);
    init_start = 1'b1;
    @(negedge clk);
    init_start = 1'b0;
    chk("R9 busy", busy, 1);
    repeat (3) @(negedge clk);
    init_start = 1'b1;   // stray start, must be ignored (R9)
    @(negedge clk);
    init_start = 1'b0;
    while (!cal_req) @(negedge clk);
    chk("R6 count", log_n - base, 7);
    for (int s = 0; s < 7; s++) chk("R6 order", log_q[base + s], exp_seq(s));
    chk("R7 refi off", refi_eff, 0);
    cal_done = 2'b01;
    repeat (6) @(negedge clk);
    chk("R7 one lane waits", cal_req, 1);
    chk("R7 no cmds", log_n - base, 7);
    cal_done = 2'b11;
    @(negedge clk);
    cal_done = 2'b00;
    chk("R8 refi held off", refi_eff, 0);
    while (!done) @(negedge clk);
    chk("R8 refi restored", refi_eff, refi_cfg);
    chk("R9 busy low at done", busy, 0);
    chk("R8 count", log_n - base, 10);
    for (int s = 7; s < 10; s++) chk("R8 refresh", log_q[base + s], exp_seq(s));
    repeat (20) @(negedge clk);
    chk("R9 single done", done_n - n0, 1);
    chk("R9 stays idle", {busy, cal_req}, 0);
    chk("R4 idle pins", idle_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule